// File: doc/BRIEF.md
# Memory Operation Address Buffer

This block holds memory operations that have left instruction dispatch but have not yet finished. It has a pool of load slots and an in-order queue of store entries. Every operation brings an immediate offset and a base register, given either as a value or as the tag of the unit that will produce it. A store also brings its data, in the same value-or-tag form. Each entry watches the shared result bus for any operand it lacks. It adds the offset to the base one cycle after the base is known, and the address field keeps the sum in place of the offset. When an entry's conditions are met, it competes for a single memory port.

Loads read memory and keep the returned word in their slot until the result bus takes it. Stores write memory when they reach the head of the queue and hold both a computed address and their data. A load stays away from memory while any store dispatched before it still has an unknown address or has the same address. Each load slot has a fixed, nonzero tag from the tag space the reservation stations use. That tag is reported at dispatch, travels with the memory read and labels the broadcast result.

Dispatch, the memory request and the result output are valid/ready streams. Whether dispatch is ready depends on the kind of operation offered (`disp_is_store`). Once the memory request or the result output raises valid, valid stays high until the handshake. The result payload does not change while it waits. The memory request payload may be replaced by a higher-priority store before it is accepted. Memory responses and result-bus snoops are plain inputs with no back-pressure.

Top module: `mem_addr_buffer`

## Requirements
- R1: `disp_ready` behaves as follows. For a load (`disp_is_store`=0) it is high when a load slot is free. For a store it is high when the store queue is not full. An accepted load takes the lowest-numbered free slot i, and `disp_ld_tag` reports LD_TAG_BASE+i (default tags 1..4, never 0).
- R2: A base or data tag of 0 means the value field is valid. A nonzero tag is resolved only by a result-bus broadcast with an equal tag, including one in the very cycle of dispatch. Broadcasts with other tags have no effect.
- R3: The address field starts as the immediate. In the cycle after the base becomes known, it is replaced by immediate+base (modulo 2^W). The entry first requests memory in the cycle after that.
- R4: A load with a computed address, and no blocking older store, raises `mem_req_valid` with `mem_req_write`=0, its address and its tag. It leaves the request once `mem_req_ready` accepts it. A raised request stays raised until accepted.
- R5: A store writes memory (`mem_req_write`=1, address, `mem_req_wdata`) only as the oldest store and only with both address and data known. Stores write in dispatch order, and a store whose data tag is unresolved never writes.
- R6: At most one request is offered per cycle. A ready store wins over ready loads, and among ready loads the lowest slot wins.
- R7: A load does not request memory while a store dispatched before it still lacks an address or has an equal address. Stores dispatched after the load never block it.
- R8: A memory response updates only the issued load whose tag it carries. A response carrying the tag of a slot that has not issued is ignored.
- R9: A completed load offers `res_valid` with its tag and data. These stay constant until `res_ready`, and the slot is freed on the handshake.
- R10: After reset every entry is empty: no memory request, no result, and dispatch ready for both kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | Dispatch accepted for the offered kind |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_imm | input | W | Immediate offset |
| disp_base_tag | input | TAG_W | Base producer tag, 0 = value present |
| disp_base_val | input | W | Base value |
| disp_data_tag | input | TAG_W | Store data producer tag, 0 = value present |
| disp_data_val | input | W | Store data value |
| disp_ld_tag | output | TAG_W | Tag given to the load being accepted |
| cdb_valid | input | 1 | Result bus broadcast |
| cdb_tag | input | TAG_W | Broadcast tag |
| cdb_data | input | W | Broadcast value |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | W | Effective address |
| mem_req_wdata | output | W | Store data |
| mem_req_tag | output | TAG_W | Load tag of a read |
| mem_rsp_valid | input | 1 | Read data returning |
| mem_rsp_tag | input | TAG_W | Tag of the returning read |
| mem_rsp_data | input | W | Read data |
| res_valid | output | 1 | Load result offered to the result bus |
| res_ready | input | 1 | Result bus grant |
| res_tag | output | TAG_W | Tag of the offered result |
| res_data | output | W | Loaded value |

## Verification
Some rules are checked by assertions on every cycle. These are the one-grant rule and store priority, the persistence of a raised memory request, the equality between a formed address and the previous cycle's offset plus base, and the stability of a stalled result. The assertions also check that no load is granted while an older store lacks an address, and that only a ready queue head is popped. The bench scenarios cover the rest. Same-address blocking and the release that follows a late data broadcast appear only in the order of requests the memory sees. The bench's memory model shows the returned values to be program-order correct. The snoop on the dispatch cycle, the ignored stray response and tag allocation are observable only through directed sequences.

// File: rtl/mab_pkg.sv
package mab_pkg;
  typedef enum logic [2:0] {
    LS_FREE,
    LS_BASE,
    LS_EA,
    LS_READY,
    LS_MEM,
    LS_DONE
  } ld_state_e;
endpackage

// File: rtl/mab_load_slot.sv
module mab_load_slot
  import mab_pkg::*;
#(
  parameter int W      = 16,
  parameter int TAG_W  = 3,
  parameter int NST    = 4,
  parameter int MY_TAG = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_i,
  input  logic [W-1:0]            imm_i,
  input  logic [TAG_W-1:0]        base_tag_i,
  input  logic [W-1:0]            base_val_i,
  input  logic                    cdb_valid_i,
  input  logic [TAG_W-1:0]        cdb_tag_i,
  input  logic [W-1:0]            cdb_data_i,
  input  logic [NST-1:0]          st_valid_i,
  input  logic [NST-1:0]          st_addr_ok_i,
  input  logic [NST-1:0][W-1:0]   st_addr_i,
  input  logic [NST-1:0]          st_free_i,
  input  logic                    mem_grant_i,
  input  logic                    rsp_valid_i,
  input  logic [TAG_W-1:0]        rsp_tag_i,
  input  logic [W-1:0]            rsp_data_i,
  input  logic                    res_take_i,
  output logic                    free_o,
  output logic                    req_o,
  output logic [W-1:0]            addr_o,
  output logic                    done_o,
  output logic [W-1:0]            data_o
);
  localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

  ld_state_e        state_q;
  logic [W-1:0]     addr_q, base_q, data_q;
  logic [TAG_W-1:0] btag_q;
  logic [NST-1:0]   older_q;
  logic [NST-1:0]   hazard;
  logic             snoop_hit, alloc_hit;

  assign snoop_hit = cdb_valid_i && (cdb_tag_i == btag_q);
  assign alloc_hit = cdb_valid_i && (cdb_tag_i == base_tag_i);

  // older stores that still hide the load's address
  always_comb begin
    for (int s = 0; s < NST; s++) begin
      hazard[s] = older_q[s] && st_valid_i[s] &&
                  (!st_addr_ok_i[s] || (st_addr_i[s] == addr_q));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LS_FREE;
      addr_q  <= '0;
      base_q  <= '0;
      data_q  <= '0;
      btag_q  <= '0;
      older_q <= '0;
    end else begin
      older_q <= older_q & ~st_free_i;
      unique case (state_q)
        LS_FREE: if (alloc_i) begin
          addr_q  <= imm_i;
          older_q <= st_valid_i & ~st_free_i;
          btag_q  <= base_tag_i;
          if (base_tag_i == '0) begin
            base_q  <= base_val_i;
            state_q <= LS_EA;
          end else if (alloc_hit) begin
            base_q  <= cdb_data_i;
            state_q <= LS_EA;
          end else begin
            state_q <= LS_BASE;
          end
        end
        LS_BASE: if (snoop_hit) begin
          base_q  <= cdb_data_i;
          state_q <= LS_EA;
        end
        LS_EA: begin
          addr_q  <= addr_q + base_q;
          state_q <= LS_READY;
        end
        LS_READY: if (mem_grant_i) state_q <= LS_MEM;
        LS_MEM: if (rsp_valid_i && (rsp_tag_i == SELF)) begin
          data_q  <= rsp_data_i;
          state_q <= LS_DONE;
        end
        LS_DONE: if (res_take_i) state_q <= LS_FREE;
        default: state_q <= LS_FREE;
      endcase
    end
  end

  assign free_o = (state_q == LS_FREE);
  assign req_o  = (state_q == LS_READY) && !(|hazard);
  assign addr_o = addr_q;
  assign done_o = (state_q == LS_DONE);
  assign data_o = data_q;

  p_grant_when_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant_i |-> state_q == LS_READY);
  p_ea_is_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_READY && $past(state_q) == LS_EA) |-> addr_q == $past(addr_q) + $past(base_q));
  p_no_unknown_older_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant_i |-> !(|(older_q & st_valid_i & ~st_addr_ok_i)));
  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_DONE && !res_take_i) |=> (state_q == LS_DONE && $stable(data_q)));
endmodule

// File: rtl/mab_store_queue.sv
module mab_store_queue #(
  parameter int W     = 16,
  parameter int TAG_W = 3,
  parameter int NST   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_i,
  input  logic [W-1:0]          imm_i,
  input  logic [TAG_W-1:0]      base_tag_i,
  input  logic [W-1:0]          base_val_i,
  input  logic [TAG_W-1:0]      data_tag_i,
  input  logic [W-1:0]          data_val_i,
  input  logic                  cdb_valid_i,
  input  logic [TAG_W-1:0]      cdb_tag_i,
  input  logic [W-1:0]          cdb_data_i,
  input  logic                  pop_i,
  output logic                  full_o,
  output logic [NST-1:0]        valid_o,
  output logic [NST-1:0]        addr_ok_o,
  output logic [NST-1:0][W-1:0] addr_o,
  output logic [NST-1:0]        free_o,
  output logic                  req_o,
  output logic [W-1:0]          head_addr_o,
  output logic [W-1:0]          head_data_o
);
  localparam int PTR_W = (NST > 1) ? $clog2(NST) : 1;

  logic [NST-1:0]            vld_q, brdy_q, aok_q, drdy_q;
  logic [NST-1:0][W-1:0]     addr_q, base_q, data_q;
  logic [NST-1:0][TAG_W-1:0] btag_q, dtag_q;
  logic [PTR_W-1:0]          head_q, tail_q;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NST - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      brdy_q <= '0;
      aok_q  <= '0;
      drdy_q <= '0;
      addr_q <= '0;
      base_q <= '0;
      data_q <= '0;
      btag_q <= '0;
      dtag_q <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      for (int e = 0; e < NST; e++) begin
        if (push_i && (tail_q == PTR_W'(e))) begin
          vld_q[e]  <= 1'b1;
          aok_q[e]  <= 1'b0;
          addr_q[e] <= imm_i;
          btag_q[e] <= base_tag_i;
          dtag_q[e] <= data_tag_i;
          if (base_tag_i == '0) begin
            brdy_q[e] <= 1'b1;
            base_q[e] <= base_val_i;
          end else if (cdb_valid_i && cdb_tag_i == base_tag_i) begin
            brdy_q[e] <= 1'b1;
            base_q[e] <= cdb_data_i;
          end else begin
            brdy_q[e] <= 1'b0;
          end
          if (data_tag_i == '0) begin
            drdy_q[e] <= 1'b1;
            data_q[e] <= data_val_i;
          end else if (cdb_valid_i && cdb_tag_i == data_tag_i) begin
            drdy_q[e] <= 1'b1;
            data_q[e] <= cdb_data_i;
          end else begin
            drdy_q[e] <= 1'b0;
          end
        end else if (vld_q[e]) begin
          if (!brdy_q[e] && cdb_valid_i && cdb_tag_i == btag_q[e]) begin
            brdy_q[e] <= 1'b1;
            base_q[e] <= cdb_data_i;
          end
          if (brdy_q[e] && !aok_q[e]) begin
            addr_q[e] <= addr_q[e] + base_q[e];
            aok_q[e]  <= 1'b1;
          end
          if (!drdy_q[e] && cdb_valid_i && cdb_tag_i == dtag_q[e]) begin
            drdy_q[e] <= 1'b1;
            data_q[e] <= cdb_data_i;
          end
          if (pop_i && (head_q == PTR_W'(e))) vld_q[e] <= 1'b0;
        end
      end
      if (push_i) tail_q <= wrap_inc(tail_q);
      if (pop_i)  head_q <= wrap_inc(head_q);
    end
  end

  always_comb begin
    free_o = '0;
    if (pop_i) free_o[head_q] = 1'b1;
  end

  assign full_o      = vld_q[tail_q];
  assign valid_o     = vld_q;
  assign addr_ok_o   = aok_q;
  assign addr_o      = addr_q;
  assign req_o       = vld_q[head_q] && aok_q[head_q] && drdy_q[head_q];
  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];

  p_push_into_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !vld_q[tail_q]);
  p_pop_complete_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (vld_q[head_q] && aok_q[head_q] && drdy_q[head_q]));
endmodule

// File: rtl/mab_port_arb.sv
module mab_port_arb #(
  parameter int W        = 16,
  parameter int TAG_W    = 3,
  parameter int NLD      = 4,
  parameter int TAG_BASE = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_req_i,
  input  logic [W-1:0]          st_addr_i,
  input  logic [W-1:0]          st_data_i,
  input  logic [NLD-1:0]        ld_req_i,
  input  logic [NLD-1:0][W-1:0] ld_addr_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output logic                  write_o,
  output logic [W-1:0]          addr_o,
  output logic [W-1:0]          wdata_o,
  output logic [TAG_W-1:0]      tag_o,
  output logic                  st_grant_o,
  output logic [NLD-1:0]        ld_grant_o
);
  localparam int IDX_W = (NLD > 1) ? $clog2(NLD) : 1;

  logic [IDX_W-1:0] sel;
  logic             found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = NLD - 1; i >= 0; i--) begin
      if (ld_req_i[i]) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    valid_o    = st_req_i || found;
    write_o    = st_req_i;
    addr_o     = st_req_i ? st_addr_i : ld_addr_i[sel];
    wdata_o    = st_req_i ? st_data_i : '0;
    tag_o      = st_req_i ? '0 : TAG_W'(TAG_BASE) + TAG_W'(sel);
    st_grant_o = st_req_i && ready_i;
    ld_grant_o = '0;
    if (!st_req_i && found && ready_i) ld_grant_o[sel] = 1'b1;
  end

  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_grant_o, ld_grant_o}));
  p_store_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld_grant_o) |-> !st_req_i);
  p_req_persists_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o);
endmodule

// File: rtl/mem_addr_buffer.sv
module mem_addr_buffer #(
  parameter int W           = 16,
  parameter int TAG_W       = 3,
  parameter int NLD         = 4,
  parameter int NST         = 4,
  parameter int LD_TAG_BASE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic             disp_is_store,
  input  logic [W-1:0]     disp_imm,
  input  logic [TAG_W-1:0] disp_base_tag,
  input  logic [W-1:0]     disp_base_val,
  input  logic [TAG_W-1:0] disp_data_tag,
  input  logic [W-1:0]     disp_data_val,
  output logic [TAG_W-1:0] disp_ld_tag,
  input  logic             cdb_valid,
  input  logic [TAG_W-1:0] cdb_tag,
  input  logic [W-1:0]     cdb_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [W-1:0]     mem_req_addr,
  output logic [W-1:0]     mem_req_wdata,
  output logic [TAG_W-1:0] mem_req_tag,
  input  logic             mem_rsp_valid,
  input  logic [TAG_W-1:0] mem_rsp_tag,
  input  logic [W-1:0]     mem_rsp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [TAG_W-1:0] res_tag,
  output logic [W-1:0]     res_data
);
  localparam int IDX_W = (NLD > 1) ? $clog2(NLD) : 1;

  logic [NLD-1:0]        ld_free, ld_req, ld_done, ld_alloc, ld_grant, ld_take;
  logic [NLD-1:0][W-1:0] ld_addr, ld_data;
  logic [NST-1:0]        st_valid, st_aok, st_free;
  logic [NST-1:0][W-1:0] st_addr;
  logic                  st_full, st_req, st_grant, st_push;
  logic [W-1:0]          st_head_addr, st_head_data;
  logic                  disp_fire, any_free, any_done;
  logic [IDX_W-1:0]      free_pick, done_pick, res_cur, res_sel_q;
  logic                  res_hold_q;

  always_comb begin
    free_pick = '0;
    any_free  = 1'b0;
    done_pick = '0;
    any_done  = 1'b0;
    for (int i = NLD - 1; i >= 0; i--) begin
      if (ld_free[i]) begin
        free_pick = IDX_W'(i);
        any_free  = 1'b1;
      end
      if (ld_done[i]) begin
        done_pick = IDX_W'(i);
        any_done  = 1'b1;
      end
    end
  end

  assign disp_ready  = disp_is_store ? !st_full : any_free;
  assign disp_fire   = disp_valid && disp_ready;
  assign disp_ld_tag = TAG_W'(LD_TAG_BASE) + TAG_W'(free_pick);
  assign st_push     = disp_fire && disp_is_store;

  always_comb begin
    ld_alloc = '0;
    if (disp_fire && !disp_is_store) ld_alloc[free_pick] = 1'b1;
  end

  // result selection is locked while the bus stalls it
  assign res_cur   = res_hold_q ? res_sel_q : done_pick;
  assign res_valid = res_hold_q || any_done;
  assign res_tag   = TAG_W'(LD_TAG_BASE) + TAG_W'(res_cur);
  assign res_data  = ld_data[res_cur];

  always_comb begin
    ld_take = '0;
    if (res_valid && res_ready) ld_take[res_cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_hold_q <= 1'b0;
      res_sel_q  <= '0;
    end else if (res_valid && !res_ready) begin
      res_hold_q <= 1'b1;
      res_sel_q  <= res_cur;
    end else begin
      res_hold_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NLD; g++) begin : g_ld
    mab_load_slot #(
      .W(W), .TAG_W(TAG_W), .NST(NST), .MY_TAG(LD_TAG_BASE + g)
    ) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (ld_alloc[g]),
      .imm_i        (disp_imm),
      .base_tag_i   (disp_base_tag),
      .base_val_i   (disp_base_val),
      .cdb_valid_i  (cdb_valid),
      .cdb_tag_i    (cdb_tag),
      .cdb_data_i   (cdb_data),
      .st_valid_i   (st_valid),
      .st_addr_ok_i (st_aok),
      .st_addr_i    (st_addr),
      .st_free_i    (st_free),
      .mem_grant_i  (ld_grant[g]),
      .rsp_valid_i  (mem_rsp_valid),
      .rsp_tag_i    (mem_rsp_tag),
      .rsp_data_i   (mem_rsp_data),
      .res_take_i   (ld_take[g]),
      .free_o       (ld_free[g]),
      .req_o        (ld_req[g]),
      .addr_o       (ld_addr[g]),
      .done_o       (ld_done[g]),
      .data_o       (ld_data[g])
    );
  end

  mab_store_queue #(.W(W), .TAG_W(TAG_W), .NST(NST)) u_sq (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (st_push),
    .imm_i       (disp_imm),
    .base_tag_i  (disp_base_tag),
    .base_val_i  (disp_base_val),
    .data_tag_i  (disp_data_tag),
    .data_val_i  (disp_data_val),
    .cdb_valid_i (cdb_valid),
    .cdb_tag_i   (cdb_tag),
    .cdb_data_i  (cdb_data),
    .pop_i       (st_grant),
    .full_o      (st_full),
    .valid_o     (st_valid),
    .addr_ok_o   (st_aok),
    .addr_o      (st_addr),
    .free_o      (st_free),
    .req_o       (st_req),
    .head_addr_o (st_head_addr),
    .head_data_o (st_head_data)
  );

  mab_port_arb #(.W(W), .TAG_W(TAG_W), .NLD(NLD), .TAG_BASE(LD_TAG_BASE)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_req_i   (st_req),
    .st_addr_i  (st_head_addr),
    .st_data_i  (st_head_data),
    .ld_req_i   (ld_req),
    .ld_addr_i  (ld_addr),
    .ready_i    (mem_req_ready),
    .valid_o    (mem_req_valid),
    .write_o    (mem_req_write),
    .addr_o     (mem_req_addr),
    .wdata_o    (mem_req_wdata),
    .tag_o      (mem_req_tag),
    .st_grant_o (st_grant),
    .ld_grant_o (ld_grant)
  );

  p_res_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_tag) && $stable(res_data)));
  p_load_tag_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && !disp_is_store) |-> disp_ld_tag != '0);
endmodule

// File: tb/mem_addr_buffer_tb.sv
module mem_addr_buffer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0, disp_is_store = 1'b0;
  logic [15:0] disp_imm = '0, disp_base_val = '0, disp_data_val = '0;
  logic [2:0]  disp_base_tag = '0, disp_data_tag = '0;
  logic        disp_ready;
  logic [2:0]  disp_ld_tag;
  logic        cdb_valid = 1'b0;
  logic [2:0]  cdb_tag = '0;
  logic [15:0] cdb_data = '0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr, mem_req_wdata;
  logic [2:0]  mem_req_tag;
  logic        mem_rsp_valid = 1'b0;
  logic [2:0]  mem_rsp_tag = '0;
  logic [15:0] mem_rsp_data = '0;
  logic        res_valid, res_ready = 1'b0;
  logic [2:0]  res_tag;
  logic [15:0] res_data;

  mem_addr_buffer u_dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0, n_err = 0;
  int mem_pct = 0, res_pct = 0;
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  logic [15:0] exp_data [8];
  logic [7:0]  exp_addr [8];
  bit          exp_busy [8];
  int          ld_out = 0;
  logic [7:0]  sx_addr [1024];
  logic [15:0] sx_data [1024];
  int          sx_wr = 0, sx_rd = 0;
  bit          lg_we [64];
  logic [15:0] lg_addr [64];
  logic [2:0]  lg_tag [64];
  int          lg_n = 0;
  bit          pend = 0, stray = 0;
  logic [2:0]  pend_tag, stray_tag;
  logic [7:0]  pend_addr;
  logic [15:0] stray_data;

  function automatic logic [15:0] init_val(input int a);
    return 16'(a * 37) ^ 16'h5A00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  // memory model: one-cycle read latency
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        mem_rsp_valid = 1'b1; mem_rsp_tag = pend_tag; mem_rsp_data = mem[pend_addr]; pend = 0;
      end else if (stray) begin
        mem_rsp_valid = 1'b1; mem_rsp_tag = stray_tag; mem_rsp_data = stray_data; stray = 0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = ($urandom_range(99) < mem_pct);
      #1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (lg_n < 64) begin
          lg_we[lg_n] = mem_req_write; lg_addr[lg_n] = mem_req_addr; lg_tag[lg_n] = mem_req_tag;
        end
        lg_n++;
        if (mem_req_write) begin
          chk(sx_rd < sx_wr, "R5", "unexpected store", 1, 0);
          if (sx_rd < sx_wr) begin
            chk(mem_req_addr == 16'(sx_addr[sx_rd]), "R5", "store order addr", mem_req_addr, sx_addr[sx_rd]);
            chk(mem_req_wdata == sx_data[sx_rd], "R5", "store data", mem_req_wdata, sx_data[sx_rd]);
            sx_rd++;
          end
          mem[mem_req_addr[7:0]] = mem_req_wdata;
        end else begin
          pend = 1; pend_tag = mem_req_tag; pend_addr = mem_req_addr[7:0];
          chk(exp_busy[mem_req_tag] && exp_addr[mem_req_tag] == mem_req_addr[7:0], "R4",
              "load request addr", mem_req_addr, exp_addr[mem_req_tag]);
        end
      end
    end
  end

  // result bus model
  initial begin
    bit prev_stall = 0;
    logic [2:0] p_tag = '0;
    logic [15:0] p_data = '0;
    forever begin
      @(negedge clk);
      res_ready = ($urandom_range(99) < res_pct);
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          chk(res_valid == 1'b1, "R9", "stalled valid", res_valid, 1);
          chk(res_tag == p_tag && res_data == p_data, "R9", "stalled payload", res_data, p_data);
        end
        if (res_valid && res_ready) begin
          chk(exp_busy[res_tag], "R9", "result tag outstanding", res_tag, 1);
          chk(res_data == exp_data[res_tag], "R8", "load value", res_data, exp_data[res_tag]);
          exp_busy[res_tag] = 0;
          ld_out--;
        end
        prev_stall = res_valid && !res_ready;
        p_tag = res_tag; p_data = res_data;
      end
    end
  end

  task automatic disp(input bit st, input logic [15:0] imm, input logic [2:0] btag,
                      input logic [15:0] bval, input logic [2:0] dtag, input logic [15:0] dval,
                      input logic [7:0] ea, input logic [15:0] val, output logic [2:0] tag);
    @(negedge clk);
    disp_valid = 1'b1; disp_is_store = st; disp_imm = imm; disp_base_tag = btag;
    disp_base_val = bval; disp_data_tag = dtag; disp_data_val = dval;
    #1;
    while (!disp_ready) begin
      @(negedge clk);
      #1;
    end
    tag = disp_ld_tag;
    if (st) begin
      sx_addr[sx_wr] = ea; sx_data[sx_wr] = val; sx_wr++; shadow[ea] = val;
    end else begin
      exp_busy[tag] = 1; exp_data[tag] = val; exp_addr[tag] = ea; ld_out++;
    end
    @(posedge clk);
    #1;
    disp_valid = 1'b0;
  endtask

  task automatic drain();
    while (ld_out != 0 || sx_rd != sx_wr) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  initial begin
    logic [2:0] t, tb_, tc_;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i); shadow[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    #1;
    chk(disp_ready == 1'b1, "R10", "load ready", disp_ready, 1);
    chk(mem_req_valid == 1'b0, "R10", "no request", mem_req_valid, 0);
    chk(res_valid == 1'b0, "R10", "no result", res_valid, 0);
    disp_is_store = 1'b1; #1;
    chk(disp_ready == 1'b1, "R10", "store ready", disp_ready, 1);

    // R2 R3 R8: pending base, stray response, wrong-tag broadcast
    mem_pct = 0; res_pct = 100;
    disp(0, 16'h0010, 3'd5, 16'h0, 3'd0, 16'h0, 8'h13, shadow[8'h13], t);
    chk(t == 3'd1, "R1", "first load tag", t, 1);
    stray = 1; stray_tag = 3'd1; stray_data = 16'hDEAD;
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = 3'd6; cdb_data = 16'h7777;
    @(negedge clk); #1;
    chk(res_valid == 1'b0, "R8", "stray response ignored", res_valid, 0);
    chk(mem_req_valid == 1'b0, "R2", "wrong tag ignored", mem_req_valid, 0);
    cdb_tag = 3'd5; cdb_data = 16'h0003;
    @(negedge clk);
    cdb_valid = 1'b0;
    #1;
    chk(mem_req_valid == 1'b0, "R3", "address cycle", mem_req_valid, 0);
    @(negedge clk); #1;
    chk(mem_req_valid == 1'b1, "R4", "load requests", mem_req_valid, 1);
    chk(mem_req_addr == 16'h0013, "R3", "imm+base", mem_req_addr, 16'h13);
    chk(mem_req_write == 1'b0 && mem_req_tag == 3'd1, "R4", "read with tag", mem_req_tag, 1);
    mem_pct = 100;
    drain();

    // R5 R7: store waiting for data blocks equal-address load only
    mem_pct = 0; lg_n = 0;
    disp(1, 16'h0020, 3'd0, 16'h0, 3'd6, 16'h0, 8'h20, 16'hBEEF, t);
    disp(0, 16'h0020, 3'd0, 16'h0, 3'd0, 16'h0, 8'h20, 16'hBEEF, tb_);
    disp(0, 16'h0021, 3'd0, 16'h0, 3'd0, 16'h0, 8'h21, shadow[8'h21], tc_);
    chk(tb_ == 3'd1 && tc_ == 3'd2, "R1", "lowest free slot", {tb_, tc_}, 6'o12);
    repeat (3) @(negedge clk);
    #1;
    chk(mem_req_valid && mem_req_addr == 16'h0021 && mem_req_tag == 3'd2, "R7",
        "unrelated load passes", mem_req_addr, 16'h21);
    mem_pct = 100;
    repeat (5) @(negedge clk);
    chk(lg_n == 1, "R5", "store holds without data", lg_n, 1);
    cdb_valid = 1'b1; cdb_tag = 3'd6; cdb_data = 16'hBEEF;
    @(negedge clk);
    cdb_valid = 1'b0;
    drain();
    chk(lg_n == 3, "R7", "request count", lg_n, 3);
    chk(lg_we[1] == 1'b1 && lg_addr[1] == 16'h0020, "R5", "store after data", lg_addr[1], 16'h20);
    chk(lg_we[2] == 1'b0 && lg_tag[2] == 3'd1, "R7", "blocked load after store", lg_tag[2], 1);

    // R6 priority and lowest slot
    mem_pct = 0; lg_n = 0;
    disp(1, 16'h0005, 3'd0, 16'h0, 3'd0, 16'h1234, 8'h05, 16'h1234, t);
    disp(0, 16'h0006, 3'd0, 16'h0, 3'd0, 16'h0, 8'h06, shadow[8'h06], t);
    disp(0, 16'h0007, 3'd0, 16'h0, 3'd0, 16'h0, 8'h07, shadow[8'h07], t);
    disp(0, 16'h0000, 3'd0, 16'h0008, 3'd0, 16'h0, 8'h08, shadow[8'h08], t);
    repeat (3) @(negedge clk);
    #1;
    chk(mem_req_valid && mem_req_write, "R6", "store first", mem_req_write, 1);
    mem_pct = 100;
    drain();
    chk(lg_we[0] == 1'b1 && lg_addr[0] == 16'h0005, "R6", "order store", lg_addr[0], 5);
    chk(lg_tag[1] == 3'd1 && lg_tag[2] == 3'd2 && lg_tag[3] == 3'd3, "R6", "slot order",
        {lg_tag[1], lg_tag[2], lg_tag[3]}, 9'o123);

    // R1 full, R9 back-pressure
    res_pct = 0;
    for (int k = 0; k < 4; k++)
      disp(0, 16'h0030 + 16'(k), 3'd0, 16'h0, 3'd0, 16'h0, 8'h30 + 8'(k), shadow[8'h30 + k], t);
    repeat (8) @(negedge clk);
    disp_is_store = 1'b0; #1;
    chk(disp_ready == 1'b0, "R1", "loads full", disp_ready, 0);
    disp_is_store = 1'b1; #1;
    chk(disp_ready == 1'b1, "R1", "store room", disp_ready, 1);
    chk(res_valid == 1'b1 && res_tag == 3'd1, "R9", "result offered", res_tag, 1);
    repeat (3) @(negedge clk);
    res_pct = 100;
    drain();

    // R2 broadcast in the dispatch cycle
    lg_n = 0;
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = 3'd4; cdb_data = 16'h0008;
    disp(0, 16'h0010, 3'd4, 16'h0, 3'd0, 16'h0, 8'h18, shadow[8'h18], t);
    cdb_valid = 1'b0;
    drain();
    chk(lg_n == 1 && lg_addr[0] == 16'h0018, "R2", "same-cycle snoop", lg_addr[0], 16'h18);

    // constrained random mix
    mem_pct = 70; res_pct = 70;
    for (int k = 0; k < 300; k++) begin
      logic [7:0]  ea;
      logic [15:0] imm, val;
      bit          busy_ea;
      ea = 8'($urandom_range(0, 15));
      imm = 16'($urandom);
      busy_ea = 0;
      for (int q = 1; q < 5; q++) if (exp_busy[q] && exp_addr[q] == ea) busy_ea = 1;
      if (($urandom_range(2) == 0) && !busy_ea) begin
        val = 16'($urandom);
        disp(1, imm, 3'd0, 16'(ea) - imm, 3'd0, val, ea, val, t);
      end else begin
        disp(0, imm, 3'd0, 16'(ea) - imm, 3'd0, 16'h0, ea, shadow[ea], t);
      end
    end
    drain();
    chk(ld_out == 0 && sx_rd == sx_wr, "R4", "random mix completes", ld_out, 0);
    report();
  end
endmodule